// File: doc/BRIEF.md
# PCI Host Bridge Control Registers

This block is the register front end of a PCI host bridge. It sits on a 32-bit CPU register bus and holds three kinds of state. The first is a 256-byte local configuration header for the bridge itself. The second is a set of base registers: a configuration target address, a memory window base and a relocatable I/O window base. The third is a data port that turns one CPU access into one configuration access on a downstream request/acknowledge port.

Configuration space is reached indirectly. Software first loads the target address register and then reads or writes the data register. The block then raises a request toward the downstream port. It holds the CPU ready signal low until that port acknowledges, and a read returns the data that comes back.

The block also decodes a 256 KiB I/O window from a probe address and flags a hit. A change of the I/O base produces a one-cycle remap pulse. Per-slot device interrupt levels are folded onto four output lines, with the line picked by the device number.

Top module: `pci_host_ctl`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC address the 64 words of the local header. A 32-bit write stores the word and a later read returns it unchanged. Byte 0 of each word sits in bits 7:0.
- R2: After reset the header word at offset 0x004 reads 0x02900080. This is command bit 7 (wait cycle) plus status bits 4, 7 and 9 (capability list, fast back-to-back, medium select timing). Every other header word reads zero.
- R3: The target address register at offset 0x1C0 keeps all 32 written bits and reads zero after reset.
- R4: The memory base register at offset 0x1C4 keeps only bits 31:24 and bit 0, which is a mask of 0xFF000001. It reads zero after reset.
- R5: The I/O base register at offset 0x1C8 resets to 0xFE240000 and keeps only bits 31:18 and bit 0, which is a mask of 0xFFFC0001. A write whose bits 31:18 equal the stored ones is ignored in full, bit 0 included.
- R6: `io_remap` is high for exactly the one cycle in which `cpu_rdy` answers an I/O base write that changed bits 31:18. It stays low for any other access.
- R7: `io_hit` is high exactly when `io_probe_addr` lies in the 256 KiB range that starts at the I/O base, with bits 17:0 taken as zero.
- R8: A word read at offset 0x220 drives `cfg_req` with `cfg_we`=0 and `cfg_addr` equal to the target address register. `cpu_rdy` stays low until `cfg_ack` is seen. In the cycle after the acknowledge, `cpu_rdy` is high and `cpu_rdata` carries `cfg_rdata`.
- R9: A word write at offset 0x220 drives `cfg_req` with `cfg_we`=1 and `cfg_wdata` equal to the CPU write data. It completes in the same way.
- R10: An access is refused when `cpu_size` is not 2 (the encoding is 0 byte, 1 half, 2 word) or when address bits 1:0 are not zero. A refused access gets `cpu_rdy` and `cpu_err` high in the next cycle, changes no register and forwards nothing.
- R11: Within the window, offsets that hold no register read zero, and writes to them change nothing.
- R12: `irq_line[k]` is the OR of the `dev_irq[s]` levels for which s mod 4 equals k. It follows the levels without a clock.
- R13: Any accepted access other than to offset 0x220 raises `cpu_rdy` for one cycle, in the cycle after the request. A read's data is presented with it, and a write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Byte offset in the register window |
| cpu_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_rdy |
| cpu_rdy | output | 1 | Access complete |
| cpu_err | output | 1 | Access refused, valid with cpu_rdy |
| cfg_req | output | 1 | Downstream configuration request, held until acknowledged |
| cfg_we | output | 1 | Downstream access direction |
| cfg_addr | output | 32 | Downstream target address |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream acknowledge, one cycle |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |
| io_probe_addr | input | 32 | CPU address tested against the I/O window |
| io_hit | output | 1 | Probe address is inside the I/O window |
| io_remap | output | 1 | One-cycle pulse when the I/O base moves |
| dev_irq | input | NSLOT | Interrupt level per device number |
| irq_line | output | 4 | Routed interrupt lines |

## Verification
The bench targets the I/O base rule by writing the same base twice with a different bit 0. A design that compares the whole word, or that lets bit 0 through on its own, would change the register and pulse `io_remap` on the second write. It probes addresses one word below, at both ends of and just past the I/O window; an off-by-one window or a wrong shift shows up as a wrong `io_hit`. During a data-port access it holds back the acknowledge for several cycles and checks that `cpu_rdy` stays low. A design that answered at once would return stale data instead of the downstream word. Narrow and misaligned writes, and writes to holes in the window, are followed by read-backs, which expose any register they wrongly changed. Interrupt patterns with two slots sharing a line reveal routing by the wrong bits of the device number.

// File: rtl/pch_pkg.sv
package pch_pkg;
  localparam int DW        = 32;
  localparam int AW        = 10;
  localparam int HDR_WORDS = 64;
  localparam int HDR_IW    = $clog2(HDR_WORDS);
  localparam int IO_SHIFT  = 18;

  localparam logic [AW-1:0] OFS_CADDR  = 10'h1C0;
  localparam logic [AW-1:0] OFS_MBASE  = 10'h1C4;
  localparam logic [AW-1:0] OFS_IOBASE = 10'h1C8;
  localparam logic [AW-1:0] OFS_CDATA  = 10'h220;

  localparam logic [DW-1:0] MBASE_MASK  = 32'hFF00_0001;
  localparam logic [DW-1:0] IOBASE_MASK = 32'hFFFC_0001;
  localparam logic [DW-1:0] IOBASE_RST  = 32'hFE24_0000;
  localparam logic [DW-1:0] HDR_W1_RST  = 32'h0290_0080;
  localparam logic [DW-1:0] IO_WIN_SIZE = 32'h0004_0000;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} fsm_e;
endpackage

// File: rtl/pch_hdr_store.sv
module pch_hdr_store
  import pch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HDR_IW-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [HDR_IW-1:0] rd_idx,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] word_q [HDR_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < HDR_WORDS; w++) begin
        word_q[w] <= (w == 1) ? HDR_W1_RST : '0;
      end
    end else if (wr_en) begin
      word_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/pch_base_regs.sv
module pch_base_regs
  import pch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          caddr_we,
  input  logic          mbase_we,
  input  logic          iobase_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] probe_addr,
  output logic [DW-1:0] caddr_q,
  output logic [DW-1:0] mbase_q,
  output logic [DW-1:0] iobase_q,
  output logic          io_remap,
  output logic          io_hit
);
  logic          io_move;
  logic [DW-1:0] io_start;

  // next-state: a base write counts only if the window really moves
  always_comb begin
    io_move  = iobase_we && (wdata[DW-1:IO_SHIFT] != iobase_q[DW-1:IO_SHIFT]);
    io_start = {iobase_q[DW-1:IO_SHIFT], {IO_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q  <= '0;
      mbase_q  <= '0;
      iobase_q <= IOBASE_RST;
      io_remap <= 1'b0;
    end else begin
      if (caddr_we) caddr_q  <= wdata;
      if (mbase_we) mbase_q  <= wdata & MBASE_MASK;
      if (io_move)  iobase_q <= wdata & IOBASE_MASK;
      io_remap <= io_move;
    end
  end

  // unsigned offset test covers both window ends in one compare
  assign io_hit = (probe_addr - io_start) < IO_WIN_SIZE;
endmodule

// File: rtl/pch_irq_route.sv
module pch_irq_route #(
  parameter int NSLOT = 8,
  parameter int NLINE = 4
) (
  input  logic [NSLOT-1:0] dev_irq,
  output logic [NLINE-1:0] irq_line
);
  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [NSLOT-1:0] hit;
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign hit[s] = ((s % NLINE) == l) ? dev_irq[s] : 1'b0;
    end
    assign irq_line[l] = |hit;
  end
endmodule

// File: rtl/pci_host_ctl.sv
module pci_host_ctl
  import pch_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NLINE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [1:0]          cpu_size,
  input  logic [DW-1:0]       cpu_wdata,
  output logic [DW-1:0]       cpu_rdata,
  output logic                cpu_rdy,
  output logic                cpu_err,
  output logic                cfg_req,
  output logic                cfg_we,
  output logic [DW-1:0]       cfg_addr,
  output logic [DW-1:0]       cfg_wdata,
  input  logic                cfg_ack,
  input  logic [DW-1:0]       cfg_rdata,
  input  logic [DW-1:0]       io_probe_addr,
  output logic                io_hit,
  output logic                io_remap,
  input  logic [NSLOT-1:0]    dev_irq,
  output logic [NLINE-1:0]    irq_line
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  fsm_e          st_q, st_d;
  logic          fmt_ok, acc_go, acc_bad;
  logic          sel_hdr, sel_caddr, sel_mbase, sel_iob, sel_cdata;
  logic [DW-1:0] hdr_rd, caddr_q, mbase_q, iobase_q, loc_rdata;
  logic          launch, req_d, rdy_d, err_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    fmt_ok    = (cpu_size == SZ_WORD) && (cpu_addr[1:0] == 2'b00);
    acc_go    = cpu_req && (st_q == ST_IDLE) && fmt_ok;
    acc_bad   = cpu_req && (st_q == ST_IDLE) && !fmt_ok;
    sel_hdr   = (cpu_addr[AW-1:8] == '0);
    sel_caddr = (cpu_addr == OFS_CADDR);
    sel_mbase = (cpu_addr == OFS_MBASE);
    sel_iob   = (cpu_addr == OFS_IOBASE);
    sel_cdata = (cpu_addr == OFS_CDATA);
  end

  pch_hdr_store u_hdr (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .wr_en   (acc_go && cpu_we && sel_hdr),
    .wr_idx  (cpu_addr[HDR_IW+1:2]),
    .wr_data (cpu_wdata),
    .rd_idx  (cpu_addr[HDR_IW+1:2]),
    .rd_data (hdr_rd)
  );

  pch_base_regs u_base (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .caddr_we   (acc_go && cpu_we && sel_caddr),
    .mbase_we   (acc_go && cpu_we && sel_mbase),
    .iobase_we  (acc_go && cpu_we && sel_iob),
    .wdata      (cpu_wdata),
    .probe_addr (io_probe_addr),
    .caddr_q    (caddr_q),
    .mbase_q    (mbase_q),
    .iobase_q   (iobase_q),
    .io_remap   (io_remap),
    .io_hit     (io_hit)
  );

  pch_irq_route #(.NSLOT(NSLOT), .NLINE(NLINE)) u_irq (
    .dev_irq  (dev_irq),
    .irq_line (irq_line)
  );

  always_comb begin
    loc_rdata = '0;
    if (sel_hdr)   loc_rdata = hdr_rd;
    if (sel_caddr) loc_rdata = caddr_q;
    if (sel_mbase) loc_rdata = mbase_q;
    if (sel_iob)   loc_rdata = iobase_q;
  end

  // next-state and response
  always_comb begin
    st_d    = st_q;
    req_d   = cfg_req;
    rdy_d   = 1'b0;
    err_d   = 1'b0;
    rdata_d = cpu_rdata;
    launch  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_go && sel_cdata) begin
          st_d   = ST_WAIT;
          req_d  = 1'b1;
          launch = 1'b1;
        end else if (acc_go) begin
          rdy_d   = 1'b1;
          rdata_d = cpu_we ? '0 : loc_rdata;
        end else if (acc_bad) begin
          rdy_d   = 1'b1;
          err_d   = 1'b1;
          rdata_d = '0;
        end
      end
      ST_WAIT: begin
        if (cfg_ack) begin
          st_d    = ST_IDLE;
          req_d   = 1'b0;
          rdy_d   = 1'b1;
          rdata_d = cfg_we ? '0 : cfg_rdata;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      st_q      <= ST_IDLE;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
      cpu_rdy   <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      st_q      <= st_d;
      cfg_req   <= req_d;
      cpu_rdy   <= rdy_d;
      cpu_err   <= err_d;
      cpu_rdata <= rdata_d;
      if (launch) begin
        cfg_we    <= cpu_we;
        cfg_addr  <= caddr_q;
        cfg_wdata <= cpu_wdata;
      end
    end
  end
endmodule

// File: rtl/pch_checker.sv
module pch_checker #(
  parameter int AW    = 10,
  parameter int NSLOT = 8,
  parameter int NLINE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic [AW-1:0]    cpu_addr,
  input logic [1:0]       cpu_size,
  input logic             cpu_rdy,
  input logic             cpu_err,
  input logic             cfg_req,
  input logic             cfg_ack,
  input logic [31:0]      cfg_addr,
  input logic [NSLOT-1:0] dev_irq,
  input logic [NLINE-1:0] irq_line
);
  AST_LOCAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cfg_req && cpu_addr != 10'h220 |=> cpu_rdy); // R13
  AST_NO_RDY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !cpu_rdy); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr)); // R8
  AST_ERR_HAS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_rdy); // R10
  AST_BAD_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cfg_req && cpu_size != 2'd2 |=> cpu_err && !cfg_req); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq == '0 |-> irq_line == '0); // R12
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq != '0 |-> irq_line != '0); // R12
endmodule

bind pci_host_ctl pch_checker #(.AW(10), .NSLOT(NSLOT), .NLINE(NLINE)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_req  (cpu_req),
  .cpu_addr (cpu_addr),
  .cpu_size (cpu_size),
  .cpu_rdy  (cpu_rdy),
  .cpu_err  (cpu_err),
  .cfg_req  (cfg_req),
  .cfg_ack  (cfg_ack),
  .cfg_addr (cfg_addr),
  .dev_irq  (dev_irq),
  .irq_line (irq_line)
);

// File: tb/test_pci_host_ctl.sv
`timescale 1ns/1ps
module test_pci_host_ctl;
  localparam int  NSLOT = 8;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rdy, cpu_err;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [31:0] io_probe_addr = '0;
  logic        io_hit, io_remap;
  logic [NSLOT-1:0] dev_irq = '0;
  logic [3:0]  irq_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pci_host_ctl #(.NSLOT(NSLOT), .NLINE(4)) i_pci_host_ctl (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [9:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic rdy, output logic err);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    rd = cpu_rdata; rdy = cpu_rdy; err = cpu_err;
  endtask

  task automatic wr32(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rdy, err;
    bus(1'b1, a, 2'd2, d, rd, rdy, err);
  endtask

  task automatic rd32(input logic [9:0] a, output logic [31:0] d);
    logic rdy, err;
    bus(1'b0, a, 2'd2, '0, d, rdy, err);
  endtask

  task automatic probe(input string rq, input logic [31:0] a, input logic exp);
    io_probe_addr = a;
    #1;
    chk(rq, {31'b0, io_hit}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d; logic rdy, err;
    bus(1'b0, 10'h004, 2'd2, '0, d, rdy, err);
    chk("R2 word1 reset", d, 32'h0290_0080);
    chk("R13 ready after one cycle", {30'b0, rdy, err}, 32'h2);
    @(negedge clk);
    chk("R13 ready lasts one cycle", {31'b0, cpu_rdy}, 32'h0);
    rd32(10'h008, d); chk("R2 other header word reset", d, 32'h0);
    rd32(10'h1C0, d); chk("R3 address reset", d, 32'h0);
    rd32(10'h1C4, d); chk("R4 memory base reset", d, 32'h0);
    rd32(10'h1C8, d); chk("R5 io base reset", d, 32'hFE24_0000);
    probe("R7 window start", 32'hFE24_0000, 1'b1);
    probe("R7 window last word", 32'hFE27_FFFC, 1'b1);
    probe("R7 just past window", 32'hFE28_0000, 1'b0);
    probe("R7 just below window", 32'hFE23_FFFC, 1'b0);
  endtask

  task automatic t_header;
    logic [31:0] d;
    wr32(10'h000, 32'h1122_3344);
    wr32(10'h0FC, 32'hA5A5_5A5A);
    wr32(10'h004, 32'h0000_0147);
    rd32(10'h000, d); chk("R1 header word 0", d, 32'h1122_3344);
    rd32(10'h0FC, d); chk("R1 header last word", d, 32'hA5A5_5A5A);
    rd32(10'h004, d); chk("R1 header word 1", d, 32'h0000_0147);
  endtask

  task automatic t_bases;
    logic [31:0] d; logic rdy, err;
    wr32(10'h1C0, 32'hDEAD_BEEF);
    rd32(10'h1C0, d); chk("R3 address all bits", d, 32'hDEAD_BEEF);
    wr32(10'h1C4, 32'hFFFF_FFFF);
    rd32(10'h1C4, d); chk("R4 memory base mask", d, 32'hFF00_0001);
    bus(1'b1, 10'h1C8, 2'd2, 32'h1234_5677, d, rdy, err);
    chk("R6 remap pulse on move", {31'b0, io_remap}, 32'h1);
    chk("R13 write data zero", d, 32'h0);
    @(negedge clk);
    chk("R6 remap single cycle", {31'b0, io_remap}, 32'h0);
    rd32(10'h1C8, d); chk("R5 io base mask", d, 32'h1234_0001);
    bus(1'b1, 10'h1C8, 2'd2, 32'h1234_0000, d, rdy, err);
    chk("R6 no remap same base", {31'b0, io_remap}, 32'h0);
    rd32(10'h1C8, d); chk("R5 same base write ignored", d, 32'h1234_0001);
    probe("R7 moved window inside", 32'h1235_0000, 1'b1);
    probe("R7 moved window past", 32'h1238_0000, 1'b0);
    probe("R7 old window now miss", 32'hFE24_0000, 1'b0);
  endtask

  task automatic t_holes;
    logic [31:0] d;
    wr32(10'h100, 32'hFFFF_FFFF);
    wr32(10'h1D0, 32'h5555_AAAA);
    rd32(10'h100, d); chk("R11 hole 0x100 reads zero", d, 32'h0);
    rd32(10'h1D0, d); chk("R11 hole 0x1D0 reads zero", d, 32'h0);
    rd32(10'h000, d); chk("R11 header untouched", d, 32'h1122_3344);
  endtask

  task automatic t_errors;
    logic [31:0] d; logic rdy, err;
    bus(1'b1, 10'h1C0, 2'd0, 32'h0BAD_0BAD, d, rdy, err);
    chk("R10 byte write error", {30'b0, rdy, err}, 32'h3);
    rd32(10'h1C0, d); chk("R10 byte write no change", d, 32'hDEAD_BEEF);
    bus(1'b1, 10'h1C2, 2'd2, 32'h0BAD_0BAD, d, rdy, err);
    chk("R10 misaligned error", {30'b0, rdy, err}, 32'h3);
    rd32(10'h1C0, d); chk("R10 misaligned no change", d, 32'hDEAD_BEEF);
    bus(1'b0, 10'h220, 2'd1, '0, d, rdy, err);
    chk("R10 half data access no forward", {29'b0, cfg_req, rdy, err}, 32'h3);
    @(negedge clk);
    chk("R10 still no forward", {31'b0, cfg_req}, 32'h0);
  endtask

  task automatic t_cfg_read;
    wr32(10'h1C0, 32'h8000_1008);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h220; cpu_size = 2'd2;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R8 request raised", {30'b0, cfg_req, cfg_we}, 32'h2);
    chk("R8 target address", cfg_addr, 32'h8000_1008);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R8 ready held while waiting", {30'b0, cpu_rdy, cfg_req}, 32'h1);
    cfg_ack = 1'b1; cfg_rdata = 32'hCAFE_F00D;
    @(negedge clk);
    cfg_ack = 1'b0; cfg_rdata = '0;
    chk("R8 completion", {30'b0, cpu_rdy, cfg_req}, 32'h2);
    chk("R8 returned data", cpu_rdata, 32'hCAFE_F00D);
  endtask

  task automatic t_cfg_write;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h220; cpu_size = 2'd2;
    cpu_wdata = 32'h0123_4567;
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R9 write request", {30'b0, cfg_req, cfg_we}, 32'h3);
    chk("R9 write data", cfg_wdata, 32'h0123_4567);
    chk("R9 ready held", {31'b0, cpu_rdy}, 32'h0);
    cfg_ack = 1'b1;
    @(negedge clk);
    cfg_ack = 1'b0;
    chk("R9 completion", {30'b0, cpu_rdy, cfg_req}, 32'h2);
  endtask

  task automatic t_irq;
    dev_irq = 8'b0010_0000; #1;
    chk("R12 slot 5 to line 1", {28'b0, irq_line}, 32'h2);
    dev_irq = 8'b1000_0001; #1;
    chk("R12 slots 0 and 7", {28'b0, irq_line}, 32'h9);
    dev_irq = 8'b0100_0100; #1;
    chk("R12 slots 2 and 6 share line 2", {28'b0, irq_line}, 32'h4);
    dev_irq = 8'b0000_0100; #1;
    chk("R12 one of two sharers left", {28'b0, irq_line}, 32'h4);
    dev_irq = '0; #1;
    chk("R12 levels dropped", {28'b0, irq_line}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_header();
    t_bases();
    t_holes();
    t_errors();
    t_cfg_read();
    t_cfg_write();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule